// File: doc/BRIEF.md
# Periodic and Alarm Interrupt Flag Unit

This block sits beside a real-time clock counter chain and turns clock activity into interrupt events. A free-running divider, advanced by a tick derived from a 32.768 kHz oscillator, produces a periodic event at one of fifteen programmable rates. A comparator checks the current BCD date, hours, minutes and seconds against four alarm registers once per update strobe. Each alarm register carries a repeat bit that removes its field from the comparison. A rising power-fail indication forms a third event.

Every event sets its own sticky flag whatever its enable is. The active-low interrupt request is the OR of every flag whose enable is set. A read of the flags register returns the flags. It clears them only when the address has been held on the flags location long enough beforehand. While the system runs from the backup cell, only the alarm can pull the request low, and only when a dedicated enable permits it. A battery-low status is captured while reset is held and is reported beside the event flags.

Top module: `rtc_irq_unit`

## Requirements
- R1: While `rst` is high and in the cycle after, the control register and the alarm registers read 0, the event flags are clear and `irq_n` is 1.
- R2: Rate field `ctrl[3:0]`: code 0 produces no periodic event. Code 1 fires every TICKS_10MS ticks, code 2 every 10*TICKS_10MS ticks, and code n from 3 to 15 every 2^(n-1) ticks. Counting restarts on every write to the control register.
- R3: Alarm registers at addresses 1 (seconds), 2 (minutes), 3 (hours) and 4 (date) hold a BCD value in bits 6:0 and a repeat bit in bit 7. A field whose repeat bit is 1 is not compared. The alarm event occurs only in a cycle with `upd` high and every compared field equal.
- R4: The flags register (address 5) reads bit0 periodic, bit1 alarm, bit2 power-fail and bit3 battery-low, with bits 7:4 zero. An event sets its flag even when its enable is 0.
- R5: Outside backup mode, `irq_n` is 0 exactly when a set flag has its enable set (control bit4 periodic, bit5 alarm, bit6 power-fail). It updates on the same edge as the flag.
- R6: A read of address 5 with `addr` held at 5 for at least HOLD_CYC cycles before the read cycle clears bits 2:0 and releases `irq_n`.
- R7: A read of address 5 after fewer than HOLD_CYC held cycles returns the flags and leaves them unchanged.
- R8: An event in the same cycle as a clearing read leaves its flag set after the read. The read returns the value from before the event.
- R9: A 0-to-1 transition of `pwr_fail` sets the power-fail flag. A level held high sets it only once.
- R10: While `on_batt` is 1, `irq_n` is 0 only when the alarm flag, the alarm enable and the backup enable (control bit7) are all 1.
- R11: The battery-low flag equals `bat_low` as sampled while `rst` was high. Later changes of `bat_low` and flag reads do not alter it.
- R12: A read returns its register value on `rdata` after the edge that samples `rd`. Writes to addresses 0 to 4 are read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse from the 32.768 kHz time base |
| upd | input | 1 | Once-per-second clock update strobe |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_date | input | 6 | Current date, BCD |
| pwr_fail | input | 1 | Power-fail detect level |
| on_batt | input | 1 | Backup-cell operation |
| bat_low | input | 1 | Battery-low comparator output |
| addr | input | 3 | Register address |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The clearing read and a new event can land on the same clock edge. The danger is a flag lost between its setting and its clearing. The bench holds the address on the flags location for the qualifying time and then raises the read strobe together with the update strobe while an every-second alarm is programmed. That read must return the flags without the alarm bit while `irq_n` goes low. A second qualified read must then show the alarm bit, and a third must show it gone.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int REG_AW  = 3;
  localparam int REG_DW  = 8;
  localparam int N_EVT   = 3;
  localparam int N_ALM   = 4;
  localparam int FLD_W   = 7;
  localparam int RATE_W  = 4;

  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_ASEC  = 3'd1;
  localparam logic [REG_AW-1:0] RA_AMIN  = 3'd2;
  localparam logic [REG_AW-1:0] RA_AHR   = 3'd3;
  localparam logic [REG_AW-1:0] RA_ADATE = 3'd4;
  localparam logic [REG_AW-1:0] RA_FLAGS = 3'd5;

  localparam int EV_PRD = 0;
  localparam int EV_ALM = 1;
  localparam int EV_PF  = 2;

  typedef struct packed {
    logic              bkup_en;
    logic              pf_en;
    logic              alm_en;
    logic              prd_en;
    logic [RATE_W-1:0] rate;
  } ctrl_t;
endpackage

// File: rtl/irq_prd_div.sv
module irq_prd_div
  import rtc_irq_pkg::*;
#(
  parameter int TICKS_10MS = 328,
  parameter int DEC_MULT   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  output logic              evt
);
  localparam int N_CODE = 1 << RATE_W;
  localparam int BIN_W  = N_CODE - 2;
  localparam int DW     = $clog2(TICKS_10MS + 1);
  localparam int MW     = $clog2(DEC_MULT + 1);

  logic [BIN_W-1:0]  bcnt;
  logic [DW-1:0]     dcnt;
  logic [MW-1:0]     mcnt;
  logic [N_CODE-1:0] bin_hit;
  logic              dec_wrap, mult_wrap, hit;

  assign dec_wrap  = (dcnt == DW'(TICKS_10MS - 1));
  assign mult_wrap = (mcnt == MW'(DEC_MULT - 1));

  // binary rates tap the shared counter: code g fires every 2^(g-1) ticks
  assign bin_hit[2:0] = '0;
  for (genvar g = 3; g < N_CODE; g++) begin : g_tap
    assign bin_hit[g] = &bcnt[g-2:0];
  end

  always_comb begin
    case (rate)
      4'd0:    hit = 1'b0;
      4'd1:    hit = dec_wrap;
      4'd2:    hit = dec_wrap && mult_wrap;
      default: hit = bin_hit[rate];
    endcase
  end

  assign evt = tick && hit;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      bcnt <= '0;
      dcnt <= '0;
      mcnt <= '0;
    end else if (tick) begin
      bcnt <= bcnt + 1'b1;
      dcnt <= dec_wrap ? '0 : dcnt + 1'b1;
      if (dec_wrap) mcnt <= mult_wrap ? '0 : mcnt + 1'b1;
    end
  end

  // R2: every enabled rate spans more than one tick
  p_no_back_to_back_r2: assert property (@(posedge clk) disable iff (rst)
    (evt && !restart) |=> !evt);
endmodule

// File: rtl/irq_alm_match.sv
module irq_alm_match
  import rtc_irq_pkg::*;
(
  input  logic                         upd,
  input  logic [N_ALM-1:0][REG_DW-1:0] alarm_regs,
  input  logic [N_ALM-1:0][FLD_W-1:0]  cur_time,
  output logic                         hit
);
  logic [N_ALM-1:0] fld_ok;

  // bit 7 of each alarm register removes its field from the compare
  for (genvar i = 0; i < N_ALM; i++) begin : g_fld
    assign fld_ok[i] = alarm_regs[i][REG_DW-1] ||
                       (alarm_regs[i][FLD_W-1:0] == cur_time[i]);
  end

  assign hit = upd && (&fld_ok);
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int HOLD_CYC   = 3,
  parameter int TICKS_10MS = 328
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        upd,
  input  logic [6:0]  cur_sec,
  input  logic [6:0]  cur_min,
  input  logic [5:0]  cur_hour,
  input  logic [5:0]  cur_date,
  input  logic        pwr_fail,
  input  logic        on_batt,
  input  logic        bat_low,
  input  logic [2:0]  addr,
  input  logic        wr,
  input  logic        rd,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        irq_n
);
  localparam int HW = $clog2(HOLD_CYC + 2);

  ctrl_t                        ctrl_q, ctrl_nxt;
  logic [N_ALM-1:0][REG_DW-1:0] alarm_q;
  logic [N_ALM-1:0][FLD_W-1:0]  cur_time;
  logic [N_EVT-1:0]             flag_q, flag_nxt, evt, en_nxt;
  logic                         blf_q, pf_prev;
  logic [HW-1:0]                hold_q;
  logic                         ctrl_wr, qualified, clr, irq_low;
  logic                         prd_evt, alm_evt;
  logic [REG_DW-1:0]            rdata_q, flags_byte;
  logic                         irq_n_q;

  assign ctrl_wr  = wr && (addr == RA_CTRL);
  assign ctrl_nxt = ctrl_wr ? ctrl_t'(wdata) : ctrl_q;
  assign cur_time = {{1'b0, cur_date}, {1'b0, cur_hour}, cur_min, cur_sec};

  irq_prd_div #(.TICKS_10MS(TICKS_10MS)) u_div (
    .clk(clk), .rst(rst), .restart(ctrl_wr), .tick(tick),
    .rate(ctrl_q.rate), .evt(prd_evt)
  );

  irq_alm_match u_alm (
    .upd(upd), .alarm_regs(alarm_q), .cur_time(cur_time), .hit(alm_evt)
  );

  // address-hold qualifier for the clearing read
  always_ff @(posedge clk) begin
    if (rst || addr != RA_FLAGS) hold_q <= '0;
    else if (hold_q != HW'(HOLD_CYC)) hold_q <= hold_q + 1'b1;
  end

  assign qualified = (hold_q == HW'(HOLD_CYC));
  assign clr       = rd && (addr == RA_FLAGS) && qualified;

  assign evt[EV_PRD] = prd_evt;
  assign evt[EV_ALM] = alm_evt;
  assign evt[EV_PF]  = pwr_fail && !pf_prev;

  // an event in the clearing cycle wins over the clear
  assign flag_nxt = (flag_q & {N_EVT{!clr}}) | evt;
  assign en_nxt   = {ctrl_nxt.pf_en, ctrl_nxt.alm_en, ctrl_nxt.prd_en};
  assign irq_low  = on_batt ? (flag_nxt[EV_ALM] && ctrl_nxt.alm_en && ctrl_nxt.bkup_en)
                            : |(flag_nxt & en_nxt);

  assign flags_byte = {{(REG_DW-N_EVT-1){1'b0}}, blf_q, flag_q};

  always_ff @(posedge clk) pf_prev <= pwr_fail;

  always_ff @(posedge clk) begin
    if (rst) blf_q <= bat_low;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      alarm_q <= '0;
      flag_q  <= '0;
      rdata_q <= '0;
      irq_n_q <= 1'b1;
    end else begin
      ctrl_q  <= ctrl_nxt;
      flag_q  <= flag_nxt;
      irq_n_q <= !irq_low;
      if (wr) begin
        case (addr)
          RA_ASEC:  alarm_q[0] <= wdata;
          RA_AMIN:  alarm_q[1] <= wdata;
          RA_AHR:   alarm_q[2] <= wdata;
          RA_ADATE: alarm_q[3] <= wdata;
          default:  ;
        endcase
      end
      if (rd) begin
        case (addr)
          RA_CTRL:  rdata_q <= ctrl_q;
          RA_ASEC:  rdata_q <= alarm_q[0];
          RA_AMIN:  rdata_q <= alarm_q[1];
          RA_AHR:   rdata_q <= alarm_q[2];
          RA_ADATE: rdata_q <= alarm_q[3];
          RA_FLAGS: rdata_q <= flags_byte;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata = rdata_q;
  assign irq_n = irq_n_q;

  // R1: enables come out of reset cleared
  p_en_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl_q == '0 && irq_n_q));
  // R3: alarm flag rises only after an update strobe
  p_alm_on_upd_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(flag_q[EV_ALM])) |-> $past(upd));
  // R5: a request always has a flag behind it
  p_irq_has_flag_r5: assert property (@(posedge clk) disable iff (rst)
    !irq_n_q |-> (|flag_q));
  // R6: a periodic flag drops only through a read of the flags location
  p_clear_by_read_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(flag_q[EV_PRD])) |-> $past(rd && addr == RA_FLAGS));
  // R10: in backup mode without the backup enable the request stays released
  p_bkup_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (on_batt && !ctrl_wr && !ctrl_q.bkup_en) |=> irq_n_q);
  // R11: battery-low status frozen outside reset
  p_blf_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(blf_q));
endmodule

// File: tb/sim_rtc_irq_unit.sv
module sim_rtc_irq_unit;
  localparam int HOLD = 3;
  localparam int T10  = 328;
  localparam int LIM  = 17000;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, upd = 1'b0;
  logic [6:0] cur_sec = '0, cur_min = '0;
  logic [5:0] cur_hour = '0, cur_date = '0;
  logic pwr_fail = 1'b0, on_batt = 1'b0, bat_low = 1'b1;
  logic [2:0] addr = 3'd6;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_n;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_irq_unit #(.HOLD_CYC(HOLD), .TICKS_10MS(T10)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .upd(upd), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .pwr_fail(pwr_fail), .on_batt(on_batt), .bat_low(bat_low), .addr(addr),
    .wr(wr), .rd(rd), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 3'd6;
  endtask

  task automatic rd_reg(input logic [2:0] a, input int hold, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b0;
    repeat (hold) @(negedge clk);
    rd = 1'b1;
    @(negedge clk); rd = 1'b0; addr = 3'd6; d = rdata;
  endtask

  function automatic int period(input int code);
    if (code == 0) return LIM;
    if (code == 1) return T10;
    if (code == 2) return 10 * T10;
    return 1 << (code - 1);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, blf;
    logic [7:0] aval [4];
    logic [3:0] acodes [5];
    aval[0] = 8'h30; aval[1] = 8'h15; aval[2] = 8'h08; aval[3] = 8'h12;
    acodes[0] = 4'b1111; acodes[1] = 4'b1110; acodes[2] = 4'b1100;
    acodes[3] = 4'b1000; acodes[4] = 4'b0000;
    blf = 8'h08;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(irq_n == 1'b1, "R1 irq after reset", irq_n, 1);
    bat_low = 1'b0;
    rd_reg(3'd0, 0, d); chk(d == 8'h00, "R1 ctrl reset", d, 0);
    rd_reg(3'd3, 0, d); chk(d == 8'h00, "R1 alarm reset", d, 0);
    rd_reg(3'd5, HOLD, d); chk(d == blf, "R11 blf captured", d, blf);
    rd_reg(3'd5, HOLD, d); chk(d == blf, "R11 blf survives read", d, blf);

    // R12 register readback
    wr_reg(3'd2, 8'hA5); rd_reg(3'd2, 0, d); chk(d == 8'hA5, "R12 readback", d, 8'hA5);
    wr_reg(3'd0, 8'h5C); rd_reg(3'd0, 0, d); chk(d == 8'h5C, "R12 ctrl readback", d, 8'h5C);

    // R2 sweep of every rate code with periodic enable on
    for (int code = 0; code < 16; code++) begin
      int k;
      wr_reg(3'd0, 8'h10 | 8'(code));
      rd_reg(3'd5, HOLD, d);
      tick = 1'b1; k = 0;
      while (k < LIM) begin
        @(negedge clk); k++;
        if (!irq_n) break;
      end
      tick = 1'b0;
      chk(k == period(code), $sformatf("R2 period code %0d", code), k, period(code));
      rd_reg(3'd5, HOLD, d);
      chk(d == (blf | (code != 0 ? 8'h01 : 8'h00)), "R4 periodic flag", d,
          blf | (code != 0 ? 8'h01 : 8'h00));
    end

    // R4/R5 flag sets with enable off, request stays high
    wr_reg(3'd0, 8'h03);
    tick = 1'b1; repeat (4) @(negedge clk); tick = 1'b0;
    chk(irq_n == 1'b1, "R5 disabled no irq", irq_n, 1);
    rd_reg(3'd5, HOLD, d); chk(d == (blf | 8'h01), "R4 flag without enable", d, blf | 8'h01);

    // R3 alarm mask sweep with alarm enable
    wr_reg(3'd0, 8'h20);
    for (int c = 0; c < 5; c++) begin
      for (int i = 0; i < 4; i++) wr_reg(3'(i + 1), {acodes[c][i], aval[i][6:0]});
      for (int m = 0; m < 16; m++) begin
        bit fire;
        fire = 1'b1;
        for (int i = 0; i < 4; i++) if (!acodes[c][i] && !m[i]) fire = 1'b0;
        @(negedge clk);
        cur_sec  = m[0] ? aval[0][6:0] : aval[0][6:0] ^ 7'h01;
        cur_min  = m[1] ? aval[1][6:0] : aval[1][6:0] ^ 7'h01;
        cur_hour = m[2] ? aval[2][5:0] : aval[2][5:0] ^ 6'h01;
        cur_date = m[3] ? aval[3][5:0] : aval[3][5:0] ^ 6'h01;
        upd = 1'b1;
        @(negedge clk); upd = 1'b0;
        chk(irq_n == !fire, $sformatf("R3 irq code %b match %b", acodes[c], m[3:0]), irq_n, !fire);
        rd_reg(3'd5, HOLD, d);
        chk(d == (blf | (fire ? 8'h02 : 8'h00)), "R3 alarm flag", d, blf | (fire ? 8'h02 : 8'h00));
      end
    end
    // R3 matching time without strobe
    repeat (5) @(negedge clk);
    rd_reg(3'd5, HOLD, d); chk(d == blf, "R3 no strobe no alarm", d, blf);

    // R9 power-fail, R6/R7 qualified and unqualified reads
    wr_reg(3'd0, 8'h40);
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk);
    chk(irq_n == 1'b0, "R9 pf irq", irq_n, 0);
    rd_reg(3'd5, HOLD - 1, d); chk(d == (blf | 8'h04), "R7 short read data", d, blf | 8'h04);
    chk(irq_n == 1'b0, "R7 short read keeps irq", irq_n, 0);
    rd_reg(3'd5, 0, d); chk(d == (blf | 8'h04), "R7 zero-hold read keeps flag", d, blf | 8'h04);
    rd_reg(3'd5, HOLD, d); chk(d == (blf | 8'h04), "R6 qualified read data", d, blf | 8'h04);
    chk(irq_n == 1'b1, "R6 irq released", irq_n, 1);
    rd_reg(3'd5, HOLD, d); chk(d == blf, "R9 level sets once", d, blf);
    pwr_fail = 1'b0;

    // R8 coincident event and clearing read
    wr_reg(3'd0, 8'h20);
    for (int i = 0; i < 4; i++) wr_reg(3'(i + 1), 8'h80);
    @(negedge clk); addr = 3'd5;
    repeat (HOLD) @(negedge clk);
    rd = 1'b1; upd = 1'b1;
    @(negedge clk); rd = 1'b0; upd = 1'b0; addr = 3'd6; d = rdata;
    chk(d == blf, "R8 read returns pre-event", d, blf);
    chk(irq_n == 1'b0, "R8 irq survives", irq_n, 0);
    rd_reg(3'd5, HOLD, d); chk(d == (blf | 8'h02), "R8 flag survives", d, blf | 8'h02);
    rd_reg(3'd5, HOLD, d); chk(d == blf, "R8 later read clears", d, blf);

    // R10 backup mode
    wr_reg(3'd0, 8'hB3);
    @(negedge clk); on_batt = 1'b1;
    tick = 1'b1; repeat (4) @(negedge clk); tick = 1'b0;
    chk(irq_n == 1'b1, "R10 periodic masked in backup", irq_n, 1);
    upd = 1'b1; @(negedge clk); upd = 1'b0;
    chk(irq_n == 1'b0, "R10 alarm drives in backup", irq_n, 0);
    rd_reg(3'd5, HOLD, d); chk(d == (blf | 8'h03), "R10 flags in backup", d, blf | 8'h03);
    wr_reg(3'd0, 8'h33);
    upd = 1'b1; @(negedge clk); upd = 1'b0;
    chk(irq_n == 1'b1, "R10 no backup enable", irq_n, 1);
    on_batt = 1'b0; @(negedge clk);
    chk(irq_n == 1'b0, "R10 normal mode resumes", irq_n, 0);

    // R11 second reset with battery good
    @(negedge clk); rst = 1'b1; bat_low = 1'b0;
    @(negedge clk);
    chk(irq_n == 1'b1, "R1 irq in reset", irq_n, 1);
    @(negedge clk); rst = 1'b0; bat_low = 1'b1;
    rd_reg(3'd5, HOLD, d); chk(d == 8'h00, "R11 blf clear and flags reset", d, 0);
    rd_reg(3'd0, 0, d); chk(d == 8'h00, "R1 ctrl cleared", d, 0);
    rd_reg(3'd5, HOLD, d); chk(d == 8'h00, "R11 blf ignores later input", d, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule